// File: doc/BRIEF.md
# Memory Access Alignment Exception Detector

This block is a purely combinational decision stage that sits beside the load/store address path. Each cycle it looks at the low bits of a computed data address, the access width and the instruction class, and reports whether the access must be stopped with an alignment exception. When it must, the block also reports which rule caused the exception. The next stage uses the flag and the cause code to suppress the access and record the reason.

Integer accesses are checked against their own width, but only while the forced-alignment control is set. Load/store multiple accesses are treated as word accesses. String accesses are treated as byte accesses and therefore never fault. Coprocessor accesses (floating-point or auxiliary unit) fault when they straddle a 16-byte span. They also fault when they break an alignment that the coprocessor asks for. A cache-block zero access faults on the attributes of its page and ignores its address.

Only the offset of the address within a 16-byte span takes part in any rule, so only that offset is an input.

Top module: `lsa_align_detect`

## Requirements
- R1: Class code 0 (integer access, store-conditional included; no reservation state is an input) gives cause 1 when `force_align` is 1 and the offset is not a multiple of the access width in bytes.
- R2: Class codes 0 (integer) and 1 (multiple) never raise the exception while `force_align` is 0.
- R3: Class code 1 (multiple) gives cause 2 when `force_align` is 1 and offset bits [1:0] are not zero, whatever the width code.
- R4: Class code 2 (string) never raises the exception, for any offset, width or control value.
- R5: Class code 3 (coprocessor) gives cause 3 whenever offset + width in bytes exceeds 16, whatever the coprocessor controls are.
- R6: Class code 3 gives cause 4 when `cop_need_opalign` is 1 and the offset is not a multiple of the width, provided the access does not straddle a 16-byte span.
- R7: Class code 3 gives cause 5 when `cop_need_word` is 1 and offset bits [1:0] are not zero, provided neither cause 3 nor cause 4 applies.
- R8: Class code 4 (cache-block zero) gives cause 6 exactly when `page_wt` or `page_ci` is 1, for any offset.
- R9: When several coprocessor rules hit at once, the lowest-numbered cause is reported.
- R10: The reserved class codes 5, 6 and 7 never raise the exception.
- R11: `align_exc` is 1 exactly when `exc_cause` is not 0, and `exc_cause` is 0 when there is no exception.
- R12: Width codes 0 to 4 select 1, 2, 4, 8 and 16 bytes. Codes 5 to 7 are handled as 16 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ea_off | input | 4 | Offset of the data effective address within a 16-byte span |
| size_lg | input | 3 | Access width code, log2 of the byte count |
| op_class | input | 3 | Instruction class code |
| force_align | input | 1 | Forced-alignment control for integer and multiple accesses |
| cop_need_opalign | input | 1 | Coprocessor asks for alignment to the access width |
| cop_need_word | input | 1 | Coprocessor asks for 4-byte alignment |
| page_wt | input | 1 | Target page is write-through |
| page_ci | input | 1 | Target page is caching-inhibited |
| align_exc | output | 1 | Alignment exception raised |
| exc_cause | output | 3 | Cause code of the exception (0 when none) |

## Verification
The assertions are immediate checks that run each time the inputs settle. They take for granted that every input holds a known 0 or 1 value. They also assume that the width code stays within its 3-bit range, with codes 5 to 7 following the 16-byte rule. The stimulus changes every input together on the falling clock edge and never leaves any bit undriven. It covers every width code and class code, the reserved codes included, so the assertions always see legal, settled values.

// File: rtl/lsa_align_pkg.sv
package lsa_align_pkg;

   localparam int CLASS_W = 3;
   localparam int CAUSE_W = 3;
   localparam int NUM_CAUSE = 6;

   typedef enum logic [CLASS_W-1:0] {
      CLS_INT   = 3'd0,
      CLS_MULT  = 3'd1,
      CLS_STR   = 3'd2,
      CLS_COP   = 3'd3,
      CLS_BZERO = 3'd4
   } op_class_e;

   typedef enum logic [CAUSE_W-1:0] {
      CAU_NONE      = 3'd0,
      CAU_INT_MIS   = 3'd1,
      CAU_MULT_MIS  = 3'd2,
      CAU_COP_SPAN  = 3'd3,
      CAU_COP_OPAL  = 3'd4,
      CAU_COP_WORD  = 3'd5,
      CAU_BZERO_PG  = 3'd6
   } cause_e;

endpackage

// File: rtl/lsa_size_dec.sv
module lsa_size_dec #(
   parameter int LINE_LG = 4,
   parameter int SIZE_W  = 3
) (
   input  logic [SIZE_W-1:0]  size_lg,
   output logic [LINE_LG:0]   bytes,
   output logic [LINE_LG-1:0] low_mask
);
   localparam int MAX_CODE = LINE_LG;

   logic [SIZE_W-1:0] eff_lg;

   initial begin
      if ((1 << SIZE_W) - 1 < MAX_CODE)
         $error("lsa_size_dec: SIZE_W too narrow for LINE_LG");
   end

   // codes beyond the span size saturate at one full span (R12)
   always_comb begin
      if (int'(size_lg) > MAX_CODE) eff_lg = SIZE_W'(MAX_CODE);
      else                           eff_lg = size_lg;
   end

   always_comb begin
      bytes = '0;
      bytes[eff_lg] = 1'b1;
   end

   always_comb begin
      low_mask = '0;
      for (int i = 0; i < LINE_LG; i++)
         low_mask[i] = (i < int'(eff_lg));
   end

endmodule

// File: rtl/lsa_span_chk.sv
module lsa_span_chk #(
   parameter int LINE_LG      = 4,
   parameter bit CROSS_BY_ADD = 1'b1
) (
   input  logic [LINE_LG-1:0] off,
   input  logic [LINE_LG:0]   bytes,
   output logic               crosses
);
   localparam int SUM_W = LINE_LG + 2;
   localparam logic [SUM_W-1:0] SPAN = SUM_W'(1 << LINE_LG);

   generate
      if (CROSS_BY_ADD) begin : g_add
         logic [SUM_W-1:0] end_pos;
         always_comb begin
            end_pos = SUM_W'(off) + SUM_W'(bytes);
            crosses = end_pos > SPAN;
         end
      end else begin : g_cmp
         // power-of-two widths: straddle iff offset passes span minus width
         logic [SUM_W-1:0] room;
         always_comb begin
            room    = SPAN - SUM_W'(bytes);
            crosses = SUM_W'(off) > room;
         end
      end
   endgenerate

endmodule

// File: rtl/lsa_rule_pick.sv
module lsa_rule_pick
   import lsa_align_pkg::*;
#(
   parameter int N_RULE = NUM_CAUSE
) (
   input  logic [N_RULE:1]     hits,
   output logic [CAUSE_W-1:0]  cause,
   output logic                any_hit
);
   initial begin
      if (N_RULE >= (1 << CAUSE_W))
         $error("lsa_rule_pick: too many rules for cause width");
   end

   // scan from the highest rule down so the lowest one wins (R9)
   always_comb begin
      cause = '0;
      for (int i = N_RULE; i >= 1; i--)
         if (hits[i]) cause = CAUSE_W'(i);
   end

   assign any_hit = |hits;

endmodule

// File: rtl/lsa_align_detect.sv
module lsa_align_detect
   import lsa_align_pkg::*;
#(
   parameter int LINE_LG      = 4,
   parameter int WORD_LG      = 2,
   parameter int SIZE_W       = 3,
   parameter bit CROSS_BY_ADD = 1'b1
) (
   input  logic [LINE_LG-1:0] ea_off,
   input  logic [SIZE_W-1:0]  size_lg,
   input  logic [2:0]         op_class,
   input  logic               force_align,
   input  logic               cop_need_opalign,
   input  logic               cop_need_word,
   input  logic               page_wt,
   input  logic               page_ci,
   output logic               align_exc,
   output logic [2:0]         exc_cause
);
   localparam logic [LINE_LG-1:0] WORD_MASK = LINE_LG'((1 << WORD_LG) - 1);

   initial begin
      if (WORD_LG > LINE_LG)
         $error("lsa_align_detect: word larger than span");
      if (LINE_LG < 1)
         $error("lsa_align_detect: LINE_LG must be positive");
   end

   logic [LINE_LG:0]   bytes;
   logic [LINE_LG-1:0] low_mask;
   logic               crosses;
   logic               mis_width;
   logic               mis_word;
   logic               is_int, is_mult, is_cop, is_bzero;
   logic [NUM_CAUSE:1] hits;
   logic               any_hit;
   logic [CAUSE_W-1:0] cause_w;

   lsa_size_dec #(.LINE_LG(LINE_LG), .SIZE_W(SIZE_W)) u_size (
      .size_lg  (size_lg),
      .bytes    (bytes),
      .low_mask (low_mask)
   );

   lsa_span_chk #(.LINE_LG(LINE_LG), .CROSS_BY_ADD(CROSS_BY_ADD)) u_span (
      .off     (ea_off),
      .bytes   (bytes),
      .crosses (crosses)
   );

   always_comb begin
      mis_width = |(ea_off & low_mask);
      mis_word  = |(ea_off & WORD_MASK);
   end

   // string and reserved codes match nothing, so they never fault
   always_comb begin
      is_int   = (op_class == CLS_INT);
      is_mult  = (op_class == CLS_MULT);
      is_cop   = (op_class == CLS_COP);
      is_bzero = (op_class == CLS_BZERO);
   end

   always_comb begin
      hits               = '0;
      hits[CAU_INT_MIS]  = is_int  & force_align & mis_width;
      hits[CAU_MULT_MIS] = is_mult & force_align & mis_word;
      hits[CAU_COP_SPAN] = is_cop  & crosses;
      hits[CAU_COP_OPAL] = is_cop  & cop_need_opalign & mis_width;
      hits[CAU_COP_WORD] = is_cop  & cop_need_word & mis_word;
      hits[CAU_BZERO_PG] = is_bzero & (page_wt | page_ci);
   end

   lsa_rule_pick #(.N_RULE(NUM_CAUSE)) u_pick (
      .hits    (hits),
      .cause   (cause_w),
      .any_hit (any_hit)
   );

   assign align_exc = any_hit;
   assign exc_cause = cause_w;

endmodule

// File: rtl/lsa_align_detect_chk.sv
module lsa_align_detect_chk #(
   parameter int LINE_LG = 4,
   parameter int SIZE_W  = 3
) (
   input logic [LINE_LG-1:0] ea_off,
   input logic [SIZE_W-1:0]  size_lg,
   input logic [2:0]         op_class,
   input logic               force_align,
   input logic               page_wt,
   input logic               page_ci,
   input logic               align_exc,
   input logic [2:0]         exc_cause
);
   int nbytes;

   always_comb begin
      nbytes = (int'(size_lg) >= LINE_LG) ? (1 << LINE_LG) : (1 << size_lg);

      a_r11_flag_matches_cause: assert (align_exc == (exc_cause != 3'd0))
         else $error("R11 flag/cause disagree");

      if (op_class == 3'd2)
         a_r4_string_silent: assert (!align_exc)
            else $error("R4 string access faulted");

      if (op_class > 3'd4)
         a_r10_reserved_silent: assert (!align_exc)
            else $error("R10 reserved class faulted");

      if ((op_class == 3'd0 || op_class == 3'd1) && !force_align)
         a_r2_no_force_no_fault: assert (!align_exc)
            else $error("R2 fault without forced alignment");

      if (op_class == 3'd4)
         a_r8_bzero_attr: assert (align_exc == (page_wt | page_ci))
            else $error("R8 cache-block zero outcome wrong");

      if (op_class == 3'd3 && (int'(ea_off) + nbytes > (1 << LINE_LG)))
         a_r5_cop_span: assert (exc_cause == 3'd3)
            else $error("R5 span crossing not reported");
   end

endmodule

bind lsa_align_detect lsa_align_detect_chk #(.LINE_LG(LINE_LG), .SIZE_W(SIZE_W)) u_chk (
   .ea_off      (ea_off),
   .size_lg     (size_lg),
   .op_class    (op_class),
   .force_align (force_align),
   .page_wt     (page_wt),
   .page_ci     (page_ci),
   .align_exc   (align_exc),
   .exc_cause   (exc_cause)
);

// File: tb/lsa_align_detect_bench.sv
module lsa_align_detect_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] ea_off = '0;
   logic [2:0] size_lg = '0;
   logic [2:0] op_class = '0;
   logic       force_align = 1'b0;
   logic       cop_need_opalign = 1'b0;
   logic       cop_need_word = 1'b0;
   logic       page_wt = 1'b0;
   logic       page_ci = 1'b0;
   logic       align_exc;
   logic [2:0] exc_cause;

   int vectors = 0;
   int miscompares = 0;

   always #2.5 clk = ~clk;

   lsa_align_detect u_lsa_align_detect (
      .ea_off           (ea_off),
      .size_lg          (size_lg),
      .op_class         (op_class),
      .force_align      (force_align),
      .cop_need_opalign (cop_need_opalign),
      .cop_need_word    (cop_need_word),
      .page_wt          (page_wt),
      .page_ci          (page_ci),
      .align_exc        (align_exc),
      .exc_cause        (exc_cause)
   );

   // expected cause, computed arithmetically from the requirements
   function automatic int model(int off, int sz, int cls, bit f, bit oa,
                                bit wd, bit wt, bit ci);
      int nb = (sz >= 4) ? 16 : (1 << sz);   // R12 width decoding
      bit mis = (off % nb) != 0;
      bit mw  = (off % 4) != 0;
      case (cls)
         0: return (f && mis) ? 1 : 0;        // R1
         1: return (f && mw) ? 2 : 0;         // R3
         3: begin
            if (off + nb > 16) return 3;     // R5
            if (oa && mis) return 4;         // R6
            if (wd && mw) return 5;          // R7
            return 0;
         end
         4: return (wt || ci) ? 6 : 0;        // R8
         default: return 0;                   // R4 string, R10 reserved
      endcase
   endfunction

   function automatic string tag(int exp, int cls, bit f, int off, int sz);
      int nb = (sz >= 4) ? 16 : (1 << sz);
      if (exp == 3 && (off % nb) != 0) return "R9";
      case (exp)
         1: return "R1";
         2: return "R3";
         3: return "R5";
         4: return "R6";
         5: return "R7";
         6: return "R8";
         default: begin
            if (cls == 2) return "R4";
            if (cls > 4) return "R10";
            if (cls == 4) return "R8";
            if (cls < 2 && !f) return "R2";
            if (sz > 4) return "R12";
            return "R11";
         end
      endcase
   endfunction

   task automatic apply(int off, int sz, int cls, bit f, bit oa, bit wd,
                        bit wt, bit ci);
      int exp;
      string t;
      @(negedge clk);
      ea_off = off[3:0]; size_lg = sz[2:0]; op_class = cls[2:0];
      force_align = f; cop_need_opalign = oa; cop_need_word = wd;
      page_wt = wt; page_ci = ci;
      @(posedge clk);
      #1;
      exp = model(off, sz, cls, f, oa, wd, wt, ci);
      t = tag(exp, cls, f, off, sz);
      vectors++;
      if (int'(exc_cause) != exp || align_exc != (exp != 0)) begin
         miscompares++;
         $display("FAIL %s off=%0d sz=%0d cls=%0d ctl=%b%b%b%b%b: got exc=%0b cause=%0d, expected exc=%0b cause=%0d",
                  t, off, sz, cls, f, oa, wd, wt, ci, align_exc, exc_cause,
                  (exp != 0), exp);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // idle inputs after reset: no exception (R11)
      apply(0, 0, 0, 0, 0, 0, 0, 0);
      // directed corners
      apply(1, 2, 0, 1, 0, 0, 0, 0);    // R1 misaligned word, forced
      apply(1, 2, 0, 0, 0, 0, 0, 0);    // R2 same, not forced
      apply(2, 0, 1, 1, 0, 0, 0, 0);    // R3 multiple checked as word
      apply(3, 4, 2, 1, 1, 1, 1, 1);    // R4 string never faults
      apply(12, 3, 3, 0, 0, 0, 0, 0);   // R5 8 bytes at 12 straddles
      apply(2, 2, 3, 0, 1, 0, 0, 0);    // R6 operand alignment
      apply(6, 3, 3, 0, 0, 1, 0, 0);    // R7 word alignment only
      apply(8, 3, 3, 0, 0, 1, 0, 0);    // R7 aligned, no fault
      apply(0, 0, 4, 0, 0, 0, 0, 1);    // R8 caching-inhibited page
      apply(5, 0, 4, 1, 1, 1, 0, 0);    // R8 plain page, odd address
      apply(13, 2, 3, 0, 1, 1, 0, 0);   // R9 span wins over alignment
      apply(7, 4, 6, 1, 1, 1, 1, 1);    // R10 reserved class
      apply(1, 7, 3, 0, 0, 0, 0, 0);    // R12 code 7 acts as 16 bytes
      // exhaustive sweep of every input combination
      for (int cls = 0; cls < 8; cls++)
         for (int sz = 0; sz < 8; sz++)
            for (int off = 0; off < 16; off++)
               for (int c = 0; c < 32; c++)
                  apply(off, sz, cls, c[4], c[3], c[2], c[1], c[0]);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: run did not complete, got timeout, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule